// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block picks instructions for execution from a pool of resident warps. The pool is split into two halves: even-numbered warps belong to issue side 0 and odd-numbered warps to issue side 1. Each cycle, each side looks at the warps of its own half and picks one eligible warp. A warp is eligible when its ready flag is set, it was not granted in the previous cycle, its next-instruction tag is a legal class, and the execution group that class needs is free. Each side picks in round-robin order. The two picks are then checked against each other. If both need the same shared group, or either one is a double-precision instruction, only one of them issues. A cycle-parity bit decides which one.

There are four execution groups. Two are sixteen-wide core groups, one per side. The third is the sixteen-wide load/store group and the fourth is the four-wide special-function group. The last two are shared by both sides. The surrounding pipeline gives each group a busy level, and these levels act as the only back-pressure. A grant is a single-cycle pulse that must be acted on in the cycle it appears; nothing is held or queued. The block itself tracks how long the special-function group is occupied.

Grants are combinational from the current inputs and the internal state. The next-cycle effects of a grant are the cooldown of the granted warp, the round-robin pointer and the special-function occupancy. These effects are registered.

Top module: `dual_issue_sched`

## Requirements
- R1: A warp with an even ID is granted only on side 0 and a warp with an odd ID only on side 1. The grant reports the full warp ID (0 to 15), and only a warp whose ready flag is high in that cycle is granted. When a side grants nothing, its warp and group outputs are 0.
- R2: The class tag is 3 bits wide: 0 integer, 1 single float, 2 double float, 3 load/store, 4 special function. Tags 5 to 7 are never issued. Classes 0, 1 and 2 on side s go to core group s. Group codes on the outputs are 0 core group 0, 1 core group 1, 2 load/store, 3 special function.
- R3: Each side grants the first eligible warp of its half, in ascending order, starting just after the warp it last actually granted and wrapping around. After reset, the search starts from the lowest warp of the half.
- R4: Two grants are made in the same cycle whenever both sides have a pick, the picks target different groups, and neither pick is double float. This covers integer+integer, float+float and mixed pairs.
- R5: When both picks target the load/store group or both target the special-function group, only one side issues. Side 0 wins in even cycles and side 1 in odd cycles, where the first cycle after reset is even. The losing side's round-robin position does not move.
- R6: When both sides have a pick and either pick is double float, only the parity winner from R5 issues. A double-float pick with no pick on the other side issues alone.
- R7: A granted warp is not eligible in the next cycle.
- R8: A special-function grant makes the special-function group unavailable for the following 8 cycles. It is available again in the 9th cycle. The other groups are not affected.
- R9: While grp_busy[g] is high, no grant targets group g. That side picks the next eligible warp whose group is free.
- R10: While rst_n is low, no grant is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | 16 | Per-warp ready flag |
| warp_class | input | 48 | Per-warp 3-bit next-instruction class; warp w at bits [3w+2:3w] |
| grp_busy | input | 4 | Per-group busy level, indexed by group code |
| iss_valid | output | 2 | Grant pulse per side |
| iss_warp0 | output | 4 | Warp ID granted on side 0 |
| iss_grp0 | output | 2 | Group code targeted by side 0 |
| iss_warp1 | output | 4 | Warp ID granted on side 1 |
| iss_grp1 | output | 2 | Group code targeted by side 1 |

## Verification
The grant outputs respond in the same cycle as the inputs that cause them. The bench therefore drives new inputs just after a falling edge and compares both grants one nanosecond later, before the next rising edge. The state a grant leaves behind takes effect from the next cycle on: the one-cycle warp cooldown, the round-robin pointer, the parity flip, and the special-function occupancy, which runs for cycles t+1 to t+8 after a grant in cycle t. The bench's model advances its own copy of that state once per compared cycle, so each expected grant reflects exactly the history that precedes it.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int CLS_W = 3;
  localparam int NUM_GRP = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 3'd0,
    CLS_SPF = 3'd1,
    CLS_DPF = 3'd2,
    CLS_MEM = 3'd3,
    CLS_XFN = 3'd4
  } iclass_e;

  typedef enum logic [1:0] {
    GRP_CORE0 = 2'd0,
    GRP_CORE1 = 2'd1,
    GRP_MEM   = 2'd2,
    GRP_XFN   = 2'd3
  } grp_e;

  function automatic logic cls_legal(input logic [CLS_W-1:0] c);
    return c <= 3'(CLS_XFN);
  endfunction

  // core classes stay on the side's own core group
  function automatic logic [1:0] cls_to_grp(input logic [CLS_W-1:0] c, input logic side);
    case (c)
      3'(CLS_MEM): return 2'(GRP_MEM);
      3'(CLS_XFN): return 2'(GRP_XFN);
      default:     return {1'b0, side};
    endcase
  endfunction
endpackage

// File: rtl/dis_rr_pick.sv
module dis_rr_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  input  logic          take,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] last_q;

  // scan downward so the nearest slot after last_q wins
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    for (int k = N; k >= 1; k--) begin
      j = (int'(last_q) + k) % N;
      if (elig[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= idx;
  end

  // R3
  pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> elig[idx]);

  // R3
  take_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> found);
endmodule

// File: rtl/dis_busy_timer.sv
module dis_busy_timer #(
  parameter int CYC = 8,
  parameter int CW  = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (start)       cnt_q <= CW'(CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R8
  xfn_start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R8
  xfn_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYC));
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import dis_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int XFN_CYC   = 8,
  localparam int HALF     = NUM_WARPS / 2,
  localparam int LID_W    = $clog2(HALF),
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WARPS-1:0]       warp_ready,
  input  logic [NUM_WARPS*CLS_W-1:0] warp_class,
  input  logic [NUM_GRP-1:0]         grp_busy,
  output logic [1:0]                 iss_valid,
  output logic [WID_W-1:0]           iss_warp0,
  output logic [1:0]                 iss_grp0,
  output logic [WID_W-1:0]           iss_warp1,
  output logic [1:0]                 iss_grp1
);
  logic [NUM_WARPS-1:0] cool_q, cool_d;
  logic                 par_q;
  logic                 xfn_busy, xfn_start;
  logic [NUM_GRP-1:0]   grp_block;
  logic [1:0]           found, take;
  logic [LID_W-1:0]     lidx [2];
  logic [CLS_W-1:0]     pcls [2];
  logic [1:0]           pgrp [2];
  logic                 clash;

  assign grp_block = grp_busy | {xfn_busy, {(NUM_GRP-1){1'b0}}};

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic [HALF-1:0] elig;

    always_comb begin
      int w;
      logic [CLS_W-1:0] c;
      for (int i = 0; i < HALF; i++) begin
        w = 2 * i + s;
        c = warp_class[w*CLS_W +: CLS_W];
        elig[i] = warp_ready[w] && !cool_q[w] && cls_legal(c)
                  && !grp_block[cls_to_grp(c, 1'(s))];
      end
    end

    dis_rr_pick #(.N(HALF)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig),
      .take  (take[s]),
      .found (found[s]),
      .idx   (lidx[s])
    );

    assign pcls[s] = warp_class[(2*int'(lidx[s]) + s)*CLS_W +: CLS_W];
    assign pgrp[s] = cls_to_grp(pcls[s], 1'(s));
  end

  // a shared group or a double-float pick forces a single issue
  assign clash = found[0] && found[1] &&
                 (pgrp[0] == pgrp[1] || pcls[0] == 3'(CLS_DPF) || pcls[1] == 3'(CLS_DPF));

  assign take[0] = rst_n && found[0] && !(clash && par_q);
  assign take[1] = rst_n && found[1] && !(clash && !par_q);

  assign iss_valid = take;
  assign iss_warp0 = take[0] ? {lidx[0], 1'b0} : '0;
  assign iss_grp0  = take[0] ? pgrp[0] : '0;
  assign iss_warp1 = take[1] ? {lidx[1], 1'b1} : '0;
  assign iss_grp1  = take[1] ? pgrp[1] : '0;

  assign xfn_start = (take[0] && pgrp[0] == 2'(GRP_XFN)) ||
                     (take[1] && pgrp[1] == 2'(GRP_XFN));

  always_comb begin
    cool_d = '0;
    if (take[0]) cool_d[{lidx[0], 1'b0}] = 1'b1;
    if (take[1]) cool_d[{lidx[1], 1'b1}] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cool_q <= '0;
      par_q  <= 1'b0;
    end else begin
      cool_q <= cool_d;
      par_q  <= ~par_q;
    end
  end

  dis_busy_timer #(.CYC(XFN_CYC)) u_xfn (
    .clk   (clk),
    .rst_n (rst_n),
    .start (xfn_start),
    .busy  (xfn_busy)
  );

  // R1
  side0_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> (!iss_warp0[0] && warp_ready[iss_warp0]));

  // R1
  side1_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> (iss_warp1[0] && warp_ready[iss_warp1]));

  // R5
  grp_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&iss_valid) |-> (iss_grp0 != iss_grp1));

  // R6
  dpf_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&iss_valid) |-> (warp_class[iss_warp0*CLS_W +: CLS_W] != 3'(CLS_DPF) &&
                      warp_class[iss_warp1*CLS_W +: CLS_W] != 3'(CLS_DPF)));

  // R7
  cool0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |=> !(iss_valid[0] && iss_warp0 == $past(iss_warp0)));

  // R7
  cool1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |=> !(iss_valid[1] && iss_warp1 == $past(iss_warp1)));

  // R9
  busy0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> !grp_busy[iss_grp0]);

  // R9
  busy1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[1] |-> !grp_busy[iss_grp1]);

  // R8
  xfn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfn_start |=> !xfn_start);
endmodule

// File: tb/test_dual_issue_sched.sv
`timescale 1ns/1ps
module test_dual_issue_sched;
  localparam int NW = 16;
  localparam int CW = 3;
  localparam int HW = NW / 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] warp_ready;
  logic [NW*CW-1:0] warp_class;
  logic [3:0]    grp_busy;
  logic [1:0]    iss_valid;
  logic [3:0]    iss_warp0, iss_warp1;
  logic [1:0]    iss_grp0, iss_grp1;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  int      m_last [2];
  bit [NW-1:0] m_cool;
  int      m_xfn;
  bit      m_par;

  always #2 clk = ~clk;

  dual_issue_sched i_dual_issue_sched (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_class(warp_class),
    .grp_busy(grp_busy), .iss_valid(iss_valid), .iss_warp0(iss_warp0),
    .iss_grp0(iss_grp0), .iss_warp1(iss_warp1), .iss_grp1(iss_grp1));

  function automatic int grp_of(int c, int s);
    if (c == 3) return 2;
    if (c == 4) return 3;
    return s;
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_all_cls(int c);
    for (int w = 0; w < NW; w++) warp_class[w*CW +: CW] = 3'(c);
  endtask

  // compare this cycle's grants with the model, then advance the model
  task automatic step(string tag);
    bit fnd [2];
    int pk [2];
    int pc [2];
    int pg [2];
    bit clash;
    bit tk [2];
    logic [6:0] e0, e1;
    #1;
    for (int s = 0; s < 2; s++) begin
      fnd[s] = 0; pk[s] = 0; pc[s] = 0; pg[s] = 0;
      for (int k = 1; k <= HW; k++) begin
        int li, w, c, g;
        bit blk;
        li = (m_last[s] + k) % HW;
        w = 2 * li + s;
        c = int'(warp_class[w*CW +: CW]);
        g = grp_of(c, s);
        blk = grp_busy[g] || (g == 3 && m_xfn > 0);
        if (!fnd[s] && warp_ready[w] && !m_cool[w] && c <= 4 && !blk) begin
          fnd[s] = 1; pk[s] = li; pc[s] = c; pg[s] = g;
        end
      end
    end
    clash = fnd[0] && fnd[1] && (pg[0] == pg[1] || pc[0] == 2 || pc[1] == 2);
    tk[0] = fnd[0] && !(clash && m_par);
    tk[1] = fnd[1] && !(clash && !m_par);
    e0 = tk[0] ? {1'b1, 4'(2*pk[0]), 2'(pg[0])} : 7'd0;
    e1 = tk[1] ? {1'b1, 4'(2*pk[1]+1), 2'(pg[1])} : 7'd0;
    chk({tag, " side0"}, {iss_valid[0], iss_warp0, iss_grp0}, e0);
    chk({tag, " side1"}, {iss_valid[1], iss_warp1, iss_grp1}, e1);
    m_cool = '0;
    for (int s = 0; s < 2; s++) if (tk[s]) begin
      m_cool[2*pk[s]+s] = 1'b1;
      m_last[s] = pk[s];
    end
    if ((tk[0] && pg[0] == 3) || (tk[1] && pg[1] == 3)) m_xfn = 8;
    else if (m_xfn > 0) m_xfn--;
    m_par = ~m_par;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    warp_ready = '1;
    grp_busy = '0;
    set_all_cls(0);
    m_last[0] = HW - 1; m_last[1] = HW - 1;
    m_cool = '0; m_xfn = 0; m_par = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R10 no grant in reset", {iss_valid, 5'd0}, 7'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // integer pairs, rotation through each half
    for (int i = 0; i < 10; i++) step("R3 R4 int pairs");
    set_all_cls(1);
    for (int i = 0; i < 4; i++) step("R4 float pairs");
    // mixed pair: side 0 load/store, side 1 integer
    for (int w = 0; w < NW; w++) warp_class[w*CW +: CW] = (w % 2 == 0) ? 3'd3 : 3'd0;
    for (int i = 0; i < 4; i++) step("R4 mixed pair");
    // illegal tags
    for (int w = 0; w < NW; w++) warp_class[w*CW +: CW] = 3'(5 + w % 3);
    for (int i = 0; i < 3; i++) step("R2 illegal class");
    // shared load/store group
    set_all_cls(3);
    for (int i = 0; i < 8; i++) step("R5 load/store clash");
    // double float on even warps against integer on odd warps
    for (int w = 0; w < NW; w++) warp_class[w*CW +: CW] = (w % 2 == 0) ? 3'd2 : 3'd0;
    for (int i = 0; i < 6; i++) step("R6 double float pairing");
    warp_ready = 16'h5555;
    for (int i = 0; i < 4; i++) step("R6 double float alone");
    // cooldown with a single ready warp
    set_all_cls(0);
    warp_ready = 16'h0001;
    for (int i = 0; i < 6; i++) step("R7 cooldown");
    // special-function occupancy while cores keep issuing
    warp_ready = '1;
    for (int w = 0; w < NW; w++) warp_class[w*CW +: CW] = (w % 2 == 0) ? 3'd4 : 3'd0;
    for (int i = 0; i < 20; i++) step("R8 xfn window");
    set_all_cls(4);
    for (int i = 0; i < 20; i++) step("R8 xfn both sides");
    // external busy on core 0 and load/store
    for (int w = 0; w < NW; w++) warp_class[w*CW +: CW] = (w % 4 < 2) ? 3'd0 : 3'd3;
    grp_busy = 4'b0001;
    for (int i = 0; i < 6; i++) step("R9 core0 busy");
    grp_busy = 4'b0100;
    for (int i = 0; i < 6; i++) step("R9 load/store busy");
    grp_busy = '0;

    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 3000; i++) begin
      warp_ready = 16'($urandom);
      for (int w = 0; w < NW; w++) begin
        int r;
        r = int'($urandom % 12);
        warp_class[w*CW +: CW] = (r < 10) ? 3'(r % 5) : 3'(5 + r % 3);
      end
      grp_busy = ($urandom % 6 == 0) ? 4'($urandom) : 4'd0;
      step("R1 R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule